// File: doc/BRIEF.md
# Duty-Cycled Wake-Up Link Controller

This controller sequences the three radios of a small battery node: a low-power wake-up receiver, a main data receiver and a transmitter. While idle, the node sleeps with every radio off. A timer then opens a listen window by powering the wake-up receiver. If a beacon heard in that window names this node as its target, the controller answers with an acknowledgement and powers the main receiver until the data ends or a timeout runs out. After that the node goes back to sleep.

To send, the controller powers the transmitter for one beacon that carries its own address and the destination. It then switches to the wake-up receiver for a programmable wait, listening for an acknowledgement from that destination. Without an answer it sends another beacon. After a programmable number of unanswered beacons it gives up and raises a one-cycle failure flag. When the right node answers, the controller signals the transmitter to send the payload and keeps it powered until the payload is done. At most one radio is powered in any cycle. All durations are counted in clock cycles and are read live from configuration inputs.

Top module: `wakeup_mac_ctrl`

## Requirements
- R1: After reset every radio is off and the node sleeps. In steady idle operation `wrx_en` is high for `cfg_listen_cycles` consecutive cycles and low for `cfg_sleep_cycles` consecutive cycles, alternating. A value of 0 is treated as 1.
- R2: A beacon (`bcn_rx_valid`=1) with `bcn_rx_dst` equal to `own_addr` in a listen cycle causes, one cycle later, a single-cycle `ack_send` with `tx_en`=1 and `ack_dst` equal to that beacon's `bcn_rx_src`.
- R3: A beacon whose target differs from `own_addr` is ignored. No acknowledgement is sent, and the listen window runs its full `cfg_listen_cycles` length.
- R4: In the cycle after an acknowledgement, `mrx_en` rises. It stays high until a cycle with `rx_data_end`=1 (it drops the next cycle) or for at most `cfg_data_timeout` cycles, and then the node sleeps.
- R5: `tx_req` sampled high while sleeping causes, one cycle later, a single-cycle `bcn_send` with `tx_en`=1, `bcn_src`=`own_addr` and `bcn_dst` equal to the captured `tx_dst`.
- R6: After each beacon, `wrx_en` is high for `cfg_beacon_period` cycles while waiting for an acknowledgement. If none arrives, the next beacon follows.
- R7: An acknowledgement (`ack_rx_valid`=1) whose `ack_rx_src` equals the beacon target, seen during the wait, gives a single-cycle `data_go` with `tx_en`=1 in the next cycle. `tx_en` then stays high until a cycle with `tx_data_done`=1 and drops the cycle after. An acknowledgement from any other source is ignored.
- R8: When the wait after beacon number `cfg_max_beacons` (0 treated as 1) expires without an acknowledgement, `tx_fail` pulses for one cycle with every radio off, and the node sleeps.
- R9: At most one of `wrx_en`, `mrx_en` and `tx_en` is high in any cycle.
- R10: `tx_req` is ignored outside the sleep phase. A request raised during a listen window starts its first beacon only after the window ends, two cycles after the last listen cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| own_addr | input | ADDR_W | Address of this node |
| cfg_sleep_cycles | input | TMR_W | Sleep phase length in cycles |
| cfg_listen_cycles | input | TMR_W | Listen window length in cycles |
| cfg_beacon_period | input | TMR_W | Acknowledgement wait after each beacon |
| cfg_data_timeout | input | TMR_W | Longest main-receiver on-time |
| cfg_max_beacons | input | RETRY_W | Beacons sent before giving up |
| tx_req | input | 1 | A packet is queued for sending |
| tx_dst | input | ADDR_W | Destination of the queued packet |
| tx_data_done | input | 1 | Transmitter finished the payload |
| ack_rx_valid | input | 1 | Acknowledgement heard by the wake-up receiver |
| ack_rx_src | input | ADDR_W | Sender of that acknowledgement |
| bcn_rx_valid | input | 1 | Beacon heard by the wake-up receiver |
| bcn_rx_src | input | ADDR_W | Beacon source address |
| bcn_rx_dst | input | ADDR_W | Beacon target address |
| rx_data_end | input | 1 | Main receiver saw the end of the data |
| wrx_en | output | 1 | Wake-up receiver power enable |
| mrx_en | output | 1 | Main receiver power enable |
| tx_en | output | 1 | Transmitter power enable |
| bcn_send | output | 1 | Send one beacon now |
| bcn_src | output | ADDR_W | Source field of the outgoing beacon |
| bcn_dst | output | ADDR_W | Target field of the outgoing beacon |
| ack_send | output | 1 | Send one acknowledgement now |
| ack_dst | output | ADDR_W | Node the acknowledgement is addressed to |
| data_go | output | 1 | Start sending the payload |
| tx_fail | output | 1 | One-cycle flag: no acknowledgement after all beacons |

## Verification
The bench sends beacons addressed elsewhere and acknowledgements from the wrong source. A controller that compares the wrong field would answer a stranger, or would start the payload toward a node that never woke up. The bench counts cycles for listen windows, acknowledgement waits and the data timeout. An off-by-one in a phase counter shows up as one cycle too many or too few. It also raises a send request in the middle of a listen window and lets the beacon budget run out, which catches a transmitter powered alongside a receiver, a missed or repeated failure pulse, and one beacon too many or too few. Random traffic is compared cycle by cycle against a reference model that the bench builds from the requirements.

// File: rtl/wmac_pkg.sv
// Shared types of the wake-up link controller.
// Assumes: one state register that drives the power enables of all radios.
package wmac_pkg;
    typedef enum logic [2:0] {
        ST_SLEEP,
        ST_LISTEN,
        ST_ACK,
        ST_RXDATA,
        ST_BCN_TX,
        ST_BCN_WAIT,
        ST_TX_GO,
        ST_TX_DATA
    } wmac_state_e;
endpackage

// File: rtl/wmac_phase_timer.sv
// Counts the cycles spent in the current phase and reports when the phase
// has lasted `limit` cycles (a limit of 0 behaves as 1).
// Assumes: `restart` is high on the edge where the phase changes.
module wmac_phase_timer #(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [TMR_W-1:0] limit,
    output logic             expired
);
    localparam logic [TMR_W-1:0] CNT_MAX = '1;

    logic [TMR_W-1:0] cnt;

    // Cycle counter: cleared on phase change, saturates at its maximum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= '0;
        end else if (cnt != CNT_MAX) begin
            cnt <= cnt + 1'b1;
        end
    end

    // The current cycle is the last of the phase.
    always_comb begin
        expired = (({1'b0, cnt} + 1'b1) >= {1'b0, limit});
    end
endmodule

// File: rtl/wmac_retry_ctr.sv
// Counts the beacons sent for the current packet and flags when the budget
// is spent (a budget of 0 behaves as 1).
// Assumes: `clr` holds while idle, `inc` pulses once per beacon.
module wmac_retry_ctr #(
    parameter int RETRY_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               inc,
    input  logic [RETRY_W-1:0] limit,
    output logic               exhausted
);
    localparam logic [RETRY_W-1:0] ONE     = RETRY_W'(1);
    localparam logic [RETRY_W-1:0] CNT_MAX = '1;

    logic [RETRY_W-1:0] sent;
    logic [RETRY_W-1:0] budget;

    // Beacon counter with saturation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sent <= '0;
        end else if (clr) begin
            sent <= '0;
        end else if (inc && sent != CNT_MAX) begin
            sent <= sent + 1'b1;
        end
    end

    // Budget of at least one beacon; compare against beacons sent.
    always_comb begin
        budget    = (limit == '0) ? ONE : limit;
        exhausted = (sent >= budget);
    end
endmodule

// File: rtl/wmac_addr_match.sv
// Address filter: flags a received strobe whose address equals a reference,
// but only while the filter is enabled.
// Assumes: strobe and address are valid in the same cycle.
module wmac_addr_match #(
    parameter int ADDR_W = 8
) (
    input  logic              enable,
    input  logic              strobe,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] ref_addr,
    output logic              hit
);
    // Qualified compare.
    always_comb begin
        hit = enable && strobe && (addr == ref_addr);
    end
endmodule

// File: rtl/wmac_fsm.sv
// Phase sequencer of the wake-up link controller: sleep/listen cycling,
// beacon answer and data reception, beacon retries and data sending.
// Assumes: phase timer and retry counter live outside; their inputs are
// combinational views of registered counts.
module wmac_fsm
    import wmac_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int TMR_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TMR_W-1:0]  cfg_sleep_cycles,
    input  logic [TMR_W-1:0]  cfg_listen_cycles,
    input  logic [TMR_W-1:0]  cfg_beacon_period,
    input  logic [TMR_W-1:0]  cfg_data_timeout,
    input  logic              tx_req,
    input  logic [ADDR_W-1:0] tx_dst,
    input  logic              tx_data_done,
    input  logic              rx_data_end,
    input  logic              bcn_hit,
    input  logic [ADDR_W-1:0] bcn_rx_src,
    input  logic              ack_hit,
    input  logic              phase_expired,
    input  logic              retry_exhausted,
    output wmac_state_e       state,
    output logic              phase_restart,
    output logic [TMR_W-1:0]  phase_limit,
    output logic              retry_clr,
    output logic              retry_inc,
    output logic [ADDR_W-1:0] target_addr,
    output logic [ADDR_W-1:0] peer_addr,
    output logic              fail_flag
);
    wmac_state_e state_nxt;
    logic        give_up;

    // Next phase from the current phase and the events of this cycle.
    always_comb begin
        state_nxt = state;
        give_up   = 1'b0;
        unique case (state)
            ST_SLEEP: begin
                if (tx_req)             state_nxt = ST_BCN_TX;
                else if (phase_expired) state_nxt = ST_LISTEN;
            end
            ST_LISTEN: begin
                if (bcn_hit)            state_nxt = ST_ACK;
                else if (phase_expired) state_nxt = ST_SLEEP;
            end
            ST_ACK:      state_nxt = ST_RXDATA;
            ST_RXDATA: begin
                if (rx_data_end || phase_expired) state_nxt = ST_SLEEP;
            end
            ST_BCN_TX:   state_nxt = ST_BCN_WAIT;
            ST_BCN_WAIT: begin
                if (ack_hit) begin
                    state_nxt = ST_TX_GO;
                end else if (phase_expired) begin
                    if (retry_exhausted) begin
                        state_nxt = ST_SLEEP;
                        give_up   = 1'b1;
                    end else begin
                        state_nxt = ST_BCN_TX;
                    end
                end
            end
            ST_TX_GO:    state_nxt = ST_TX_DATA;
            ST_TX_DATA: begin
                if (tx_data_done) state_nxt = ST_SLEEP;
            end
            default:     state_nxt = ST_SLEEP;
        endcase
    end

    // Phase length that applies to the current phase.
    always_comb begin
        unique case (state)
            ST_SLEEP:    phase_limit = cfg_sleep_cycles;
            ST_LISTEN:   phase_limit = cfg_listen_cycles;
            ST_RXDATA:   phase_limit = cfg_data_timeout;
            ST_BCN_WAIT: phase_limit = cfg_beacon_period;
            default:     phase_limit = '0;
        endcase
    end

    // Controls for the timer and the beacon counter.
    always_comb begin
        phase_restart = (state_nxt != state);
        retry_clr     = (state == ST_SLEEP);
        retry_inc     = (state == ST_BCN_TX);
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_SLEEP;
        else        state <= state_nxt;
    end

    // Captures the beacon target when a send starts.
    always_ff @(posedge clk) begin
        if (!rst_n)                                          target_addr <= '0;
        else if (state == ST_SLEEP && state_nxt == ST_BCN_TX) target_addr <= tx_dst;
    end

    // Captures the beacon sender that is to be acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n)                                        peer_addr <= '0;
        else if (state == ST_LISTEN && state_nxt == ST_ACK) peer_addr <= bcn_rx_src;
    end

    // One-cycle failure flag after the last unanswered beacon.
    always_ff @(posedge clk) begin
        if (!rst_n) fail_flag <= 1'b0;
        else        fail_flag <= give_up;
    end
endmodule

// File: rtl/wakeup_mac_ctrl.sv
// Top of the duty-cycled wake-up link controller. Connects the sequencer,
// the phase timer, the beacon retry counter and two address filters, and
// decodes the radio enables and strobes from the phase.
// Assumes: all inputs synchronous to clk; own_addr is static while running.
module wakeup_mac_ctrl
    import wmac_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int TMR_W   = 16,
    parameter int RETRY_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  own_addr,
    input  logic [TMR_W-1:0]   cfg_sleep_cycles,
    input  logic [TMR_W-1:0]   cfg_listen_cycles,
    input  logic [TMR_W-1:0]   cfg_beacon_period,
    input  logic [TMR_W-1:0]   cfg_data_timeout,
    input  logic [RETRY_W-1:0] cfg_max_beacons,
    input  logic               tx_req,
    input  logic [ADDR_W-1:0]  tx_dst,
    input  logic               tx_data_done,
    input  logic               ack_rx_valid,
    input  logic [ADDR_W-1:0]  ack_rx_src,
    input  logic               bcn_rx_valid,
    input  logic [ADDR_W-1:0]  bcn_rx_src,
    input  logic [ADDR_W-1:0]  bcn_rx_dst,
    input  logic               rx_data_end,
    output logic               wrx_en,
    output logic               mrx_en,
    output logic               tx_en,
    output logic               bcn_send,
    output logic [ADDR_W-1:0]  bcn_src,
    output logic [ADDR_W-1:0]  bcn_dst,
    output logic               ack_send,
    output logic [ADDR_W-1:0]  ack_dst,
    output logic               data_go,
    output logic               tx_fail
);
    wmac_state_e       state;
    logic              phase_restart;
    logic [TMR_W-1:0]  phase_limit;
    logic              phase_expired;
    logic              retry_clr;
    logic              retry_inc;
    logic              retry_exhausted;
    logic              bcn_hit;
    logic              ack_hit;
    logic [ADDR_W-1:0] target_addr;
    logic [ADDR_W-1:0] peer_addr;
    logic              fail_flag;

    wmac_addr_match #(.ADDR_W(ADDR_W)) u_bcn_filter (
        .enable   (state == ST_LISTEN),
        .strobe   (bcn_rx_valid),
        .addr     (bcn_rx_dst),
        .ref_addr (own_addr),
        .hit      (bcn_hit)
    );

    wmac_addr_match #(.ADDR_W(ADDR_W)) u_ack_filter (
        .enable   (state == ST_BCN_WAIT),
        .strobe   (ack_rx_valid),
        .addr     (ack_rx_src),
        .ref_addr (target_addr),
        .hit      (ack_hit)
    );

    wmac_phase_timer #(.TMR_W(TMR_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (phase_restart),
        .limit   (phase_limit),
        .expired (phase_expired)
    );

    wmac_retry_ctr #(.RETRY_W(RETRY_W)) u_retry (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (retry_clr),
        .inc       (retry_inc),
        .limit     (cfg_max_beacons),
        .exhausted (retry_exhausted)
    );

    wmac_fsm #(.ADDR_W(ADDR_W), .TMR_W(TMR_W)) u_fsm (
        .clk               (clk),
        .rst_n             (rst_n),
        .cfg_sleep_cycles  (cfg_sleep_cycles),
        .cfg_listen_cycles (cfg_listen_cycles),
        .cfg_beacon_period (cfg_beacon_period),
        .cfg_data_timeout  (cfg_data_timeout),
        .tx_req            (tx_req),
        .tx_dst            (tx_dst),
        .tx_data_done      (tx_data_done),
        .rx_data_end       (rx_data_end),
        .bcn_hit           (bcn_hit),
        .bcn_rx_src        (bcn_rx_src),
        .ack_hit           (ack_hit),
        .phase_expired     (phase_expired),
        .retry_exhausted   (retry_exhausted),
        .state             (state),
        .phase_restart     (phase_restart),
        .phase_limit       (phase_limit),
        .retry_clr         (retry_clr),
        .retry_inc         (retry_inc),
        .target_addr       (target_addr),
        .peer_addr         (peer_addr),
        .fail_flag         (fail_flag)
    );

    // Radio enables and strobes decoded from the phase.
    always_comb begin
        wrx_en   = (state == ST_LISTEN) || (state == ST_BCN_WAIT);
        mrx_en   = (state == ST_RXDATA);
        tx_en    = (state == ST_ACK) || (state == ST_BCN_TX) ||
                   (state == ST_TX_GO) || (state == ST_TX_DATA);
        bcn_send = (state == ST_BCN_TX);
        ack_send = (state == ST_ACK);
        data_go  = (state == ST_TX_GO);
        bcn_src  = own_addr;
        bcn_dst  = target_addr;
        ack_dst  = peer_addr;
        tx_fail  = fail_flag;
    end
endmodule

// File: rtl/wmac_checker.sv
// Protocol checks of the wake-up link controller, seen at its ports.
// Assumes: bound to every instance of wakeup_mac_ctrl.
module wmac_checker #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wrx_en,
    input logic              mrx_en,
    input logic              tx_en,
    input logic              bcn_send,
    input logic              ack_send,
    input logic [ADDR_W-1:0] ack_dst,
    input logic [ADDR_W-1:0] bcn_rx_src,
    input logic              data_go,
    input logic              tx_fail
);
    assert_radio_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wrx_en, mrx_en, tx_en}));

    assert_beacon_on_tx_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bcn_send |-> tx_en);

    assert_beacon_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bcn_send |=> !bcn_send);

    assert_ack_on_tx_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ack_send |-> tx_en);

    assert_ack_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ack_send |=> !ack_send);

    assert_ack_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ack_send |-> (ack_dst == $past(bcn_rx_src)));

    assert_mrx_after_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mrx_en) |-> $past(ack_send));

    assert_go_after_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
        data_go |-> $past(wrx_en));

    assert_fail_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_fail |=> !tx_fail);

    assert_fail_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_fail |-> !(wrx_en || mrx_en || tx_en));
endmodule

bind wakeup_mac_ctrl wmac_checker #(.ADDR_W(ADDR_W)) u_wmac_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .wrx_en     (wrx_en),
    .mrx_en     (mrx_en),
    .tx_en      (tx_en),
    .bcn_send   (bcn_send),
    .ack_send   (ack_send),
    .ack_dst    (ack_dst),
    .bcn_rx_src (bcn_rx_src),
    .data_go    (data_go),
    .tx_fail    (tx_fail)
);

// File: tb/wakeup_mac_ctrl_test.sv
module wakeup_mac_ctrl_test;
    localparam int AW = 8;
    localparam int TW = 16;
    localparam int RW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] own_addr = 8'h5A;
    logic [TW-1:0] cfg_sleep = 16'd3, cfg_listen = 16'd4, cfg_period = 16'd3, cfg_tmo = 16'd5;
    logic [RW-1:0] cfg_maxb = 4'd2;
    logic          tx_req = 0, tx_data_done = 0, ack_rx_valid = 0, bcn_rx_valid = 0, rx_data_end = 0;
    logic [AW-1:0] tx_dst = 0, ack_rx_src = 0, bcn_rx_src = 0, bcn_rx_dst = 0;
    logic          wrx_en, mrx_en, tx_en, bcn_send, ack_send, data_go, tx_fail;
    logic [AW-1:0] bcn_src, bcn_dst, ack_dst;

    int checks = 0;
    int errors = 0;
    bit model_on = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    wakeup_mac_ctrl #(.ADDR_W(AW), .TMR_W(TW), .RETRY_W(RW)) uut (
        .clk(clk), .rst_n(rst_n), .own_addr(own_addr),
        .cfg_sleep_cycles(cfg_sleep), .cfg_listen_cycles(cfg_listen),
        .cfg_beacon_period(cfg_period), .cfg_data_timeout(cfg_tmo),
        .cfg_max_beacons(cfg_maxb), .tx_req(tx_req), .tx_dst(tx_dst),
        .tx_data_done(tx_data_done), .ack_rx_valid(ack_rx_valid), .ack_rx_src(ack_rx_src),
        .bcn_rx_valid(bcn_rx_valid), .bcn_rx_src(bcn_rx_src), .bcn_rx_dst(bcn_rx_dst),
        .rx_data_end(rx_data_end), .wrx_en(wrx_en), .mrx_en(mrx_en), .tx_en(tx_en),
        .bcn_send(bcn_send), .bcn_src(bcn_src), .bcn_dst(bcn_dst), .ack_send(ack_send),
        .ack_dst(ack_dst), .data_go(data_go), .tx_fail(tx_fail)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model of the requirements (phase codes local to the bench).
    localparam int P_SLEEP = 0, P_LISTEN = 1, P_ACK = 2, P_RXD = 3;
    localparam int P_BTX = 4, P_BWAIT = 5, P_GO = 6, P_TXD = 7;
    int            m_ph, m_cnt, m_sent;
    logic [AW-1:0] m_tgt, m_peer;
    logic          m_fail;

    function automatic bit phase_done(input int c, input int lim);
        return (c + 1) >= lim;
    endfunction

    function automatic int beacon_budget(input int lim);
        return (lim == 0) ? 1 : lim;
    endfunction

    always @(posedge clk) begin
        int nx;
        if (!rst_n) begin
            m_ph <= P_SLEEP; m_cnt <= 0; m_sent <= 0; m_tgt <= 0; m_peer <= 0; m_fail <= 0;
        end else begin
            nx = m_ph;
            m_fail <= 0;
            case (m_ph)
                P_SLEEP: begin
                    m_sent <= 0;
                    if (tx_req) begin nx = P_BTX; m_tgt <= tx_dst; end
                    else if (phase_done(m_cnt, int'(cfg_sleep))) nx = P_LISTEN;
                end
                P_LISTEN: begin
                    if (bcn_rx_valid && bcn_rx_dst == own_addr) begin nx = P_ACK; m_peer <= bcn_rx_src; end
                    else if (phase_done(m_cnt, int'(cfg_listen))) nx = P_SLEEP;
                end
                P_ACK: nx = P_RXD;
                P_RXD: if (rx_data_end || phase_done(m_cnt, int'(cfg_tmo))) nx = P_SLEEP;
                P_BTX: begin nx = P_BWAIT; m_sent <= m_sent + 1; end
                P_BWAIT: begin
                    if (ack_rx_valid && ack_rx_src == m_tgt) nx = P_GO;
                    else if (phase_done(m_cnt, int'(cfg_period))) begin
                        if (m_sent >= beacon_budget(int'(cfg_maxb))) begin nx = P_SLEEP; m_fail <= 1; end
                        else nx = P_BTX;
                    end
                end
                P_GO: nx = P_TXD;
                default: if (tx_data_done) nx = P_SLEEP;
            endcase
            m_cnt <= (nx != m_ph) ? 0 : m_cnt + 1;
            m_ph  <= nx;
        end
    end

    // Per-cycle comparison, 1 ns after the edge.
    always @(posedge clk) begin
        #1;
        if (rst_n && model_on && !finished) begin
            check(wrx_en == (m_ph == P_LISTEN || m_ph == P_BWAIT), "R1/R6 wrx_en vs model", wrx_en, m_ph);
            check(mrx_en == (m_ph == P_RXD), "R4 mrx_en vs model", mrx_en, m_ph);
            check(tx_en == (m_ph == P_ACK || m_ph == P_BTX || m_ph == P_GO || m_ph == P_TXD),
                  "R7 tx_en vs model", tx_en, m_ph);
            check(ack_send == (m_ph == P_ACK), "R2 ack_send vs model", ack_send, m_ph);
            if (ack_send) check(ack_dst == m_peer, "R2 ack_dst", ack_dst, m_peer);
            check(bcn_send == (m_ph == P_BTX), "R5 bcn_send vs model", bcn_send, m_ph);
            if (bcn_send) begin
                check(bcn_dst == m_tgt, "R5 bcn_dst", bcn_dst, m_tgt);
                check(bcn_src == own_addr, "R5 bcn_src", bcn_src, own_addr);
            end
            check(data_go == (m_ph == P_GO), "R7 data_go vs model", data_go, m_ph);
            check(tx_fail == m_fail, "R8 tx_fail vs model", tx_fail, m_fail);
            check((32'(wrx_en) + 32'(mrx_en) + 32'(tx_en)) <= 1, "R9 one radio at most",
                  {wrx_en, mrx_en, tx_en}, 0);
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic clear_inputs();
        @(negedge clk);
        tx_req = 0; tx_data_done = 0; ack_rx_valid = 0; bcn_rx_valid = 0; rx_data_end = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    // Waits for the first cycle of a listen window.
    task automatic wait_listen();
        int g = 0;
        tick();
        while (wrx_en && g < 1000) begin tick(); g++; end
        while (!wrx_en && g < 2000) begin tick(); g++; end
    endtask

    task automatic random_run(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            tx_req       = ($urandom_range(0, 19) == 0);
            tx_data_done = ($urandom_range(0, 4) == 0);
            rx_data_end  = ($urandom_range(0, 5) == 0);
            bcn_rx_valid = ($urandom_range(0, 5) == 0);
            bcn_rx_src   = AW'($urandom);
            bcn_rx_dst   = $urandom_range(0, 1) ? own_addr : own_addr ^ 8'h01;
            ack_rx_valid = ($urandom_range(0, 3) == 0);
            ack_rx_src   = $urandom_range(0, 2) != 0 ? tx_dst : tx_dst ^ 8'h80;
        end
    endtask

    initial begin
        int n, b, w;
        bit seen;
        void'($urandom(32'd20240611));
        // R1: reset state
        repeat (2) @(posedge clk);
        #1;
        check(!wrx_en && !mrx_en && !tx_en && !bcn_send && !ack_send && !data_go && !tx_fail,
              "R1 all off in reset", {wrx_en, mrx_en, tx_en}, 0);
        @(negedge clk);
        rst_n = 1;
        model_on = 1;

        // R1: window and sleep lengths
        wait_listen();
        n = 1;
        tick();
        while (wrx_en && n < 100) begin n++; tick(); end
        check(n == int'(cfg_listen), "R1 listen length", n, cfg_listen);
        w = 1;
        tick();
        while (!wrx_en && w < 100) begin w++; tick(); end
        check(w == int'(cfg_sleep), "R1 sleep length", w, cfg_sleep);

        // R3: foreign beacon is ignored
        wait_listen();
        @(negedge clk);
        bcn_rx_valid = 1; bcn_rx_dst = 8'h33; bcn_rx_src = 8'h21;
        n = 1; seen = 0;
        tick();
        @(negedge clk);
        bcn_rx_valid = 0;
        while (wrx_en && n < 100) begin n++; seen |= ack_send; tick(); end
        seen |= ack_send;
        check(n == int'(cfg_listen) && !seen, "R3 foreign beacon ignored", n, cfg_listen);

        // R2 + R4: own beacon, acknowledgement, data timeout
        wait_listen();
        @(negedge clk);
        bcn_rx_valid = 1; bcn_rx_dst = own_addr; bcn_rx_src = 8'h77;
        tick();
        check(ack_send && tx_en && ack_dst == 8'h77, "R2 ack to beacon source", ack_dst, 8'h77);
        @(negedge clk);
        bcn_rx_valid = 0;
        n = 0;
        tick();
        while (mrx_en && n < 100) begin n++; tick(); end
        check(n == int'(cfg_tmo), "R4 main receiver timeout", n, cfg_tmo);

        // R4: end of data ends reception early
        wait_listen();
        @(negedge clk);
        bcn_rx_valid = 1; bcn_rx_dst = own_addr; bcn_rx_src = 8'h10;
        tick();
        @(negedge clk);
        bcn_rx_valid = 0;
        tick();
        check(mrx_en, "R4 main receiver on after ack", mrx_en, 1);
        @(negedge clk);
        rx_data_end = 1;
        tick();
        check(!mrx_en && !wrx_en && !tx_en, "R4 end of data", mrx_en, 0);
        @(negedge clk);
        rx_data_end = 0;

        // R10: request raised in a listen window waits for sleep
        wait_listen();
        @(negedge clk);
        tx_req = 1; tx_dst = 8'h44;
        n = 0;
        do begin tick(); n++; end while (!bcn_send && n < 100);
        check(n == int'(cfg_listen) + 1, "R10 request deferred to sleep", n, cfg_listen + 1);

        // R6 + R8: no answer, give up after the budget
        @(negedge clk);
        tx_req = 0;
        b = 1; w = 0;
        tick();
        while (!tx_fail && b < 50) begin
            if (bcn_send) b++;
            if (wrx_en) w++;
            tick();
        end
        check(b == int'(cfg_maxb), "R8 beacons before failure", b, cfg_maxb);
        check(w == int'(cfg_maxb) * int'(cfg_period), "R6 ack wait length", w, cfg_maxb * cfg_period);
        check(tx_fail && !tx_en, "R8 failure flag", tx_fail, 1);

        // R5 + R7: beacon, foreign ack ignored, target ack starts data
        @(negedge clk);
        tx_req = 1; tx_dst = 8'h44;
        tick();
        check(bcn_send && tx_en && bcn_dst == 8'h44 && bcn_src == own_addr, "R5 beacon fields", bcn_dst, 8'h44);
        @(negedge clk);
        tx_req = 0;
        tick();
        @(negedge clk);
        ack_rx_valid = 1; ack_rx_src = 8'h45;
        tick();
        check(!data_go && wrx_en, "R7 foreign ack ignored", data_go, 0);
        @(negedge clk);
        ack_rx_src = 8'h44;
        tick();
        check(data_go && tx_en, "R7 data start on target ack", data_go, 1);
        @(negedge clk);
        ack_rx_valid = 0;
        for (int i = 0; i < 3; i++) begin
            tick();
            check(tx_en && !data_go, "R7 transmitter held for data", tx_en, 1);
        end
        @(negedge clk);
        tx_data_done = 1;
        tick();
        check(!tx_en, "R7 transmitter off after data", tx_en, 0);
        clear_inputs();

        // Random traffic against the model, several configurations
        for (int seg = 0; seg < 5; seg++) begin
            model_on = 0;
            do_reset();
            own_addr   = AW'($urandom);
            tx_dst     = AW'($urandom);
            cfg_sleep  = TW'($urandom_range(0, 8));
            cfg_listen = TW'($urandom_range(0, 6));
            cfg_period = TW'($urandom_range(0, 5));
            cfg_tmo    = TW'($urandom_range(0, 8));
            cfg_maxb   = RW'($urandom_range(0, 3));
            model_on = 1;
            random_run(3000);
            clear_inputs();
        end

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule